// File: doc/BRIEF.md
# Integer Execution Unit with Barrel Shifter

This block is the integer datapath of a load/store RISC core, with no storage of its own. In one combinational pass it takes two register operands, a 16-bit immediate, a 5-bit constant shift amount and an operation code. It returns a 32-bit result, a destination write-enable and an overflow-exception flag. The register file sits outside the block. It supplies the operands and commits the result when the write-enable is high.

The operations are:
- add and subtract, each in a trapping form and a wrapping form;
- the four bitwise operations;
- logical and arithmetic shifts, by a constant or by a register amount;
- signed and unsigned set-on-less-than, against a register or against an immediate;
- load-upper-immediate.

The operation code decides whether the immediate is extended with its sign bit or with zeros. Codes that name no operation produce nothing: result 0, no write and no exception. The operation codes are listed in the requirements that use them.

Top module: `alu_core`

## Requirements
- R1: For a trapping add (op 0), trapping subtract (op 2) or trapping add-immediate (op 16), signed overflow raises `ovf_trap` and drops `wr_en` to 0. `result` still shows the wrapped value.
- R2: A trapping operation without overflow gives `result` = opa+opb (op 0), opa-opb (op 2) or opa+sign-extended imm (op 16), with `wr_en`=1 and `ovf_trap`=0.
- R3: The wrapping forms give the same result as their trapping counterparts, keep `ovf_trap`=0 and keep `wr_en`=1, even when the operation overflows. These are add (op 1), subtract (op 3) and add-immediate (op 17).
- R4: The bitwise operations on opa and opb are and (op 4), or (op 5), xor (op 6) and nor (op 7). A nor of a value with itself yields its complement.
- R5: The immediate is sign-extended for add-immediate (ops 16, 17) and for set-less-than-immediate (ops 18, 19). It is zero-extended for the and-, or- and xor-immediate operations (ops 20, 21, 22), which combine it with opa.
- R6: The constant shifts move opb by `shamt`. Shift left (op 8) and logical right (op 9) fill with zeros. Arithmetic right (op 10) fills with the sign bit of opb.
- R7: The variable shifts move opb by opa[4:0] and ignore opa[31:5]. They are left (op 11), logical right (op 12) and arithmetic right (op 13). The fill rules are the same as in R6.
- R8: Set-less-than compares opa with opb and writes 1 or 0. The signed form is op 14 and the unsigned form is op 15. With opa=1 and opb=0xFFFFFFFF, op 14 gives 0 and op 15 gives 1.
- R9: Set-less-than-immediate compares opa with the sign-extended immediate. The signed form is op 18 and the unsigned form is op 19. With opa=1 and imm=0xFFFF, op 18 gives 0 and op 19 gives 1.
- R10: Load-upper-immediate (op 23) puts imm in result[31:16] and clears result[15:0].
- R11: The operation codes 24 to 31 give `result`=0, `wr_en`=0 and `ovf_trap`=0.
- R12: `ovf_trap` is never raised by any operation code other than 0, 2 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code |
| opa | input | 32 | First register operand; its low 5 bits are the variable shift amount |
| opb | input | 32 | Second register operand; the value that is shifted |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write is allowed |
| ovf_trap | output | 1 | Signed-overflow exception of a trapping operation |

## Verification
The hardest case to reach from the ports is signed overflow at the exact wrap boundary. The operands must share a sign for an add, or differ in sign for a subtract, and land one step past the most positive or most negative value. Uniform random operands hit that boundary exactly only rarely, and they almost never give the immediate-form overflow with a sign-extended 0xFFFF. The stimulus therefore draws most operands from a small pool: 0, 1, all-ones, the most positive value and the most negative value. It adds directed vectors for each trapping form next to its wrapping twin, so that the write-enable and the exception flag are compared on identical inputs.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDW  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBW  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_SLL   = 5'd8,
    OP_SRL   = 5'd9,
    OP_SRA   = 5'd10,
    OP_SLLV  = 5'd11,
    OP_SRLV  = 5'd12,
    OP_SRAV  = 5'd13,
    OP_SLT   = 5'd14,
    OP_SLTU  = 5'd15,
    OP_ADDI  = 5'd16,
    OP_ADDIW = 5'd17,
    OP_SLTI  = 5'd18,
    OP_SLTIU = 5'd19,
    OP_ANDI  = 5'd20,
    OP_ORI   = 5'd21,
    OP_XORI  = 5'd22,
    OP_LUI   = 5'd23
  } alu_op_e;

  typedef enum logic [2:0] {
    UNIT_NONE  = 3'd0,
    UNIT_ADD   = 3'd1,
    UNIT_LOGIC = 3'd2,
    UNIT_SHIFT = 3'd3,
    UNIT_CMP   = 3'd4,
    UNIT_UPPER = 3'd5
  } unit_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_e;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2
  } shift_e;

  typedef enum logic [1:0] {
    BSRC_REG  = 2'd0,
    BSRC_SEXT = 2'd1,
    BSRC_ZEXT = 2'd2
  } bsrc_e;

  typedef struct packed {
    logic   legal;
    unit_e  unit;
    logic   sub;
    logic   trap;
    logic   cmp_uns;
    logic_e lop;
    shift_e sop;
    logic   sh_var;
    bsrc_e  bsrc;
  } ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [4:0] op,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl.legal   = 1'b1;
    ctrl.unit    = UNIT_NONE;
    ctrl.sub     = 1'b0;
    ctrl.trap    = 1'b0;
    ctrl.cmp_uns = 1'b0;
    ctrl.lop     = LG_AND;
    ctrl.sop     = SH_LEFT;
    ctrl.sh_var  = 1'b0;
    ctrl.bsrc    = BSRC_REG;
    case (alu_op_e'(op))
      OP_ADD:   begin ctrl.unit = UNIT_ADD; ctrl.trap = 1'b1; end
      OP_ADDW:  ctrl.unit = UNIT_ADD;
      OP_SUB:   begin ctrl.unit = UNIT_ADD; ctrl.sub = 1'b1; ctrl.trap = 1'b1; end
      OP_SUBW:  begin ctrl.unit = UNIT_ADD; ctrl.sub = 1'b1; end
      OP_AND:   begin ctrl.unit = UNIT_LOGIC; ctrl.lop = LG_AND; end
      OP_OR:    begin ctrl.unit = UNIT_LOGIC; ctrl.lop = LG_OR;  end
      OP_XOR:   begin ctrl.unit = UNIT_LOGIC; ctrl.lop = LG_XOR; end
      OP_NOR:   begin ctrl.unit = UNIT_LOGIC; ctrl.lop = LG_NOR; end
      OP_SLL:   begin ctrl.unit = UNIT_SHIFT; ctrl.sop = SH_LEFT; end
      OP_SRL:   begin ctrl.unit = UNIT_SHIFT; ctrl.sop = SH_RLOG; end
      OP_SRA:   begin ctrl.unit = UNIT_SHIFT; ctrl.sop = SH_RARI; end
      OP_SLLV:  begin ctrl.unit = UNIT_SHIFT; ctrl.sop = SH_LEFT; ctrl.sh_var = 1'b1; end
      OP_SRLV:  begin ctrl.unit = UNIT_SHIFT; ctrl.sop = SH_RLOG; ctrl.sh_var = 1'b1; end
      OP_SRAV:  begin ctrl.unit = UNIT_SHIFT; ctrl.sop = SH_RARI; ctrl.sh_var = 1'b1; end
      OP_SLT:   begin ctrl.unit = UNIT_CMP; ctrl.sub = 1'b1; end
      OP_SLTU:  begin ctrl.unit = UNIT_CMP; ctrl.sub = 1'b1; ctrl.cmp_uns = 1'b1; end
      OP_ADDI:  begin ctrl.unit = UNIT_ADD; ctrl.trap = 1'b1; ctrl.bsrc = BSRC_SEXT; end
      OP_ADDIW: begin ctrl.unit = UNIT_ADD; ctrl.bsrc = BSRC_SEXT; end
      OP_SLTI:  begin ctrl.unit = UNIT_CMP; ctrl.sub = 1'b1; ctrl.bsrc = BSRC_SEXT; end
      OP_SLTIU: begin
        ctrl.unit = UNIT_CMP; ctrl.sub = 1'b1; ctrl.cmp_uns = 1'b1; ctrl.bsrc = BSRC_SEXT;
      end
      OP_ANDI:  begin ctrl.unit = UNIT_LOGIC; ctrl.lop = LG_AND; ctrl.bsrc = BSRC_ZEXT; end
      OP_ORI:   begin ctrl.unit = UNIT_LOGIC; ctrl.lop = LG_OR;  ctrl.bsrc = BSRC_ZEXT; end
      OP_XORI:  begin ctrl.unit = UNIT_LOGIC; ctrl.lop = LG_XOR; ctrl.bsrc = BSRC_ZEXT; end
      OP_LUI:   ctrl.unit = UNIT_UPPER;
      default:  ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             ovf,
  output logic             lt_s,
  output logic             lt_u
);

  localparam int MSB = WIDTH - 1;

  // Adds a and b, or a and the complement of b plus one when sub is set.
  // The top bit of the returned vector is the carry out.
  function automatic logic [WIDTH:0] add_carry(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y,
                                               input logic             neg);
    logic [WIDTH-1:0] yy;
    yy = neg ? ~y : y;
    return {1'b0, x} + {1'b0, yy} + {{WIDTH{1'b0}}, neg};
  endfunction

  // Signed overflow: the operands that actually meet in the adder have the
  // same sign, and the sum's sign differs from it.
  function automatic logic sign_ovf(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [WIDTH:0] raw;
  logic           b_msb_eff;

  assign raw       = add_carry(a, b, sub);
  assign sum       = raw[MSB:0];
  assign b_msb_eff = sub ? ~b[MSB] : b[MSB];
  assign ovf       = sign_ovf(a[MSB], b_msb_eff, raw[MSB]);
  assign lt_s      = raw[MSB] ^ ovf;
  assign lt_u      = ~raw[WIDTH];

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_e           lop,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    case (lop)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = ~(a | b);
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val,
  input  logic [SHW-1:0]   amt,
  input  shift_e           kind,
  output logic [WIDTH-1:0] res
);

  logic             to_left;
  logic             fill;
  logic [WIDTH-1:0] pre;
  logic [WIDTH-1:0] stg [0:SHW];

  assign to_left = (kind == SH_LEFT);
  assign fill    = (kind == SH_RARI) & val[WIDTH-1];

  // A left shift is a right shift of the bit-reversed value.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign pre[i] = to_left ? val[WIDTH-1-i] : val[i];
    assign res[i] = to_left ? stg[SHW][WIDTH-1-i] : stg[SHW][i];
  end

  assign stg[0] = pre;

  // Stage k moves the value right by 2**k places when amt[k] is set.
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][WIDTH-1:STEP]} : stg[k];
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [4:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [IMM_W-1:0] imm,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic             ovf_trap
);

  localparam int PAD = WIDTH - IMM_W;

  function automatic logic [WIDTH-1:0] ext_imm(input logic [IMM_W-1:0] v,
                                               input logic             signed_ext);
    return {{PAD{signed_ext & v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [WIDTH-1:0] upper_imm(input logic [IMM_W-1:0] v);
    return {v, {PAD{1'b0}}};
  endfunction

  ctrl_t            ctrl;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             ovf_raw;
  logic             lt_s;
  logic             lt_u;
  logic             lt_sel;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] shift_res;
  logic [SHW-1:0]   sh_amt;
  logic             trap_hit;

  alu_decode u_dec (
    .op   (op),
    .ctrl (ctrl)
  );

  always_comb begin
    case (ctrl.bsrc)
      BSRC_SEXT: b_eff = ext_imm(imm, 1'b1);
      BSRC_ZEXT: b_eff = ext_imm(imm, 1'b0);
      default:   b_eff = opb;
    endcase
  end

  alu_addsub #(.WIDTH(WIDTH)) u_add (
    .a    (opa),
    .b    (b_eff),
    .sub  (ctrl.sub),
    .sum  (sum),
    .ovf  (ovf_raw),
    .lt_s (lt_s),
    .lt_u (lt_u)
  );

  alu_logic #(.WIDTH(WIDTH)) u_log (
    .a   (opa),
    .b   (b_eff),
    .lop (ctrl.lop),
    .res (logic_res)
  );

  assign sh_amt = ctrl.sh_var ? opa[SHW-1:0] : shamt;

  alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_sh (
    .val  (opb),
    .amt  (sh_amt),
    .kind (ctrl.sop),
    .res  (shift_res)
  );

  assign lt_sel   = ctrl.cmp_uns ? lt_u : lt_s;
  assign trap_hit = ctrl.trap & ovf_raw;
  assign ovf_trap = trap_hit;
  assign wr_en    = ctrl.legal & ~trap_hit;

  always_comb begin
    case (ctrl.unit)
      UNIT_ADD:   result = sum;
      UNIT_LOGIC: result = logic_res;
      UNIT_SHIFT: result = shift_res;
      UNIT_CMP:   result = {{(WIDTH-1){1'b0}}, lt_sel};
      UNIT_UPPER: result = upper_imm(imm);
      default:    result = '0;
    endcase
  end

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = 5
) (
  input logic [4:0]       op,
  input logic [WIDTH-1:0] opb,
  input logic [SHW-1:0]   shamt,
  input logic [WIDTH-1:0] result,
  input logic             wr_en,
  input logic             ovf_trap,
  input logic             ovf_raw
);

  logic is_trap_op;
  logic is_wrap_op;
  logic is_cmp_op;
  logic is_undef;

  assign is_trap_op = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
  assign is_wrap_op = (op == OP_ADDW) || (op == OP_SUBW) || (op == OP_ADDIW);
  assign is_cmp_op  = (op == OP_SLT) || (op == OP_SLTU) || (op == OP_SLTI) || (op == OP_SLTIU);
  assign is_undef   = (op > OP_LUI);

  always_comb begin
    // R1: an overflowing trapping operation flags and withholds the write
    a_r1_trap_blocks_write: assert (!(is_trap_op && ovf_raw) || (ovf_trap && !wr_en))
      else $error("R1 trapping overflow did not block the write");
    // R3: wrapping forms always write and never flag
    a_r3_no_overflow: assert (!is_wrap_op || (!ovf_trap && wr_en))
      else $error("R3 wrapping operation raised the exception");
    // R12: only the trapping codes can flag
    a_r12_trap_only_trapping: assert (!ovf_trap || is_trap_op)
      else $error("R12 exception from a non-trapping code");
    // R8: compare results are a single bit
    a_r8_cmp_boolean: assert (!is_cmp_op || (result[WIDTH-1:1] == '0))
      else $error("R8 compare result wider than one bit");
    // R10: load-upper clears the low half
    a_r10_upper_low_clear: assert (!(op == OP_LUI) || (result[IMM_W-1:0] == '0))
      else $error("R10 low half not cleared");
    // R5: zero-extended immediate with and leaves the upper bits clear
    a_r5_andi_upper_clear: assert (!(op == OP_ANDI) || (result[WIDTH-1:IMM_W] == '0))
      else $error("R5 and-immediate set upper bits");
    // R6: right shifts by a nonzero constant fill the top bit as required
    a_r6_right_fill: assert (!(shamt != '0) ||
                             ((op != OP_SRA || result[WIDTH-1] == opb[WIDTH-1]) &&
                              (op != OP_SRL || result[WIDTH-1] == 1'b0)))
      else $error("R6 wrong fill in right shift");
    // R11: undefined codes are quiet
    a_r11_undefined_quiet: assert (!is_undef || (!wr_en && !ovf_trap && result == '0))
      else $error("R11 undefined code produced output");
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W), .SHW(SHW)) u_chk (
  .op       (op),
  .opb      (opb),
  .shamt    (shamt),
  .result   (result),
  .wr_en    (wr_en),
  .ovf_trap (ovf_trap),
  .ovf_raw  (ovf_raw)
);

// File: tb/test_alu_core.sv
module test_alu_core;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op = 5'd0;
  logic [31:0] opa = 32'd0;
  logic [31:0] opb = 32'd0;
  logic [15:0] imm = 16'd0;
  logic [4:0]  shamt = 5'd0;
  logic [31:0] result;
  logic        wr_en;
  logic        ovf_trap;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  alu_core i_alu_core (
    .op       (op),
    .opa      (opa),
    .opb      (opb),
    .imm      (imm),
    .shamt    (shamt),
    .result   (result),
    .wr_en    (wr_en),
    .ovf_trap (ovf_trap)
  );

  // Behavioural reference: wide integer arithmetic, language shift operators.
  task automatic model(input logic [4:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh,
                       output logic [31:0] r, output logic we, output logic tr,
                       output string tag);
    longint    sa, sb, wide;
    logic [31:0] sx, zx;
    logic      ov;
    int        amt;
    sx = {{16{im[15]}}, im};
    zx = {16'd0, im};
    sa = longint'($signed(a));
    ov = 1'b0;
    r  = 32'd0;
    amt = int'(a % 32);
    tag = "R11";
    case (c)
      5'd0, 5'd1, 5'd16, 5'd17: begin
        sb = (c >= 5'd16) ? longint'($signed(sx)) : longint'($signed(b));
        wide = sa + sb;
        r = 32'(wide);
        ov = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        tag = (c == 5'd0 || c == 5'd16) ? (ov ? "R1" : "R2") : "R3";
        if (c >= 5'd16 && tag != "R1") tag = "R5";
      end
      5'd2, 5'd3: begin
        wide = sa - longint'($signed(b));
        r = 32'(wide);
        ov = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        tag = (c == 5'd2) ? (ov ? "R1" : "R2") : "R3";
      end
      5'd4: begin r = a & b;    tag = "R4"; end
      5'd5: begin r = a | b;    tag = "R4"; end
      5'd6: begin r = a ^ b;    tag = "R4"; end
      5'd7: begin r = ~(a | b); tag = "R4"; end
      5'd8:  begin r = b << sh; tag = "R6"; end
      5'd9:  begin r = b >> sh; tag = "R6"; end
      5'd10: begin r = 32'($signed(b) >>> sh); tag = "R6"; end
      5'd11: begin r = b << amt; tag = "R7"; end
      5'd12: begin r = b >> amt; tag = "R7"; end
      5'd13: begin r = 32'($signed(b) >>> amt); tag = "R7"; end
      5'd14: begin r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R8"; end
      5'd15: begin r = (a < b) ? 32'd1 : 32'd0; tag = "R8"; end
      5'd18: begin r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; tag = "R9"; end
      5'd19: begin r = (a < sx) ? 32'd1 : 32'd0; tag = "R9"; end
      5'd20: begin r = a & zx; tag = "R5"; end
      5'd21: begin r = a | zx; tag = "R5"; end
      5'd22: begin r = a ^ zx; tag = "R5"; end
      5'd23: begin r = {im, 16'd0}; tag = "R10"; end
      default: r = 32'd0;
    endcase
    tr = (c == 5'd0 || c == 5'd2 || c == 5'd16) && ov;
    we = (c <= 5'd23) && !tr;
  endtask

  task automatic compare(input string what);
    logic [31:0] er;
    logic        ewe, etr;
    string       tag;
    bit          bad;
    model(op, opa, opb, imm, shamt, er, ewe, etr, tag);
    vectors++;
    bad = 1'b0;
    if (result !== er) begin
      $display("FAIL %s %s op=%0d result actual=%h expected=%h", tag, what, op, result, er);
      bad = 1'b1;
    end
    if (wr_en !== ewe) begin
      $display("FAIL %s %s op=%0d wr_en actual=%b expected=%b", tag, what, op, wr_en, ewe);
      bad = 1'b1;
    end
    if (ovf_trap !== etr) begin
      $display("FAIL %s %s op=%0d ovf_trap actual=%b expected=%b",
               (op == 5'd0 || op == 5'd2 || op == 5'd16) ? tag : "R12", what, op, ovf_trap, etr);
      bad = 1'b1;
    end
    if (bad) miscompares++;
  endtask

  task automatic apply(input logic [4:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input string what);
    @(posedge clk);
    #1;
    op = c; opa = a; opb = b; imm = im; shamt = sh;
    @(negedge clk);
    compare(what);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'h0000_0000;
      3: return 32'hFFFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("idle state under reset R2");
    rst = 1'b0;

    // R1 / R3: overflow at the positive and negative wrap points
    apply(5'd0,  32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, "R1 add overflow");
    apply(5'd1,  32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, "R3 wrapping add");
    apply(5'd2,  32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0, "R1 sub overflow");
    apply(5'd3,  32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0, "R3 wrapping sub");
    apply(5'd16, 32'h7FFF_FFFF, 32'h0,         16'h0001, 5'd0, "R1 addi overflow");
    apply(5'd16, 32'h8000_0000, 32'h0,         16'hFFFF, 5'd0, "R1 addi negative overflow");
    apply(5'd17, 32'h8000_0000, 32'h0,         16'hFFFF, 5'd0, "R3 wrapping addi");
    apply(5'd2,  32'h0000_0005, 32'h0000_0007, 16'h0, 5'd0, "R2 sub no overflow");
    // R5: sign and zero extension
    apply(5'd16, 32'h0000_0000, 32'h0,         16'hFFFF, 5'd0, "R5 addi sign extend");
    apply(5'd20, 32'hFFFF_FFFF, 32'h0,         16'hFFFF, 5'd0, "R5 andi zero extend");
    apply(5'd21, 32'hAC51_0000, 32'h0,         16'h65D9, 5'd0, "R5 ori zero extend");
    // R4
    apply(5'd7,  32'hABCD_1234, 32'hABCD_1234, 16'h0, 5'd0, "R4 nor self");
    apply(5'd6,  32'hABCD_1234, 32'hFFFF_0000, 16'h0, 5'd0, "R4 xor");
    // R6 / R7
    apply(5'd8,  32'h0,         32'hABCD_1234, 16'h0, 5'd8, "R6 sll 8");
    apply(5'd10, 32'h0,         32'hABCD_1234, 16'h0, 5'd4, "R6 sra 4");
    apply(5'd9,  32'h0,         32'hABCD_1234, 16'h0, 5'd31, "R6 srl 31");
    apply(5'd12, 32'hFFFF_FFF0, 32'hABCD_1234, 16'h0, 5'd3, "R7 srlv upper bits ignored");
    apply(5'd13, 32'h0000_0020, 32'h8000_0000, 16'h0, 5'd7, "R7 srav by 32 is by 0");
    apply(5'd11, 32'h0000_001F, 32'h0000_0001, 16'h0, 5'd0, "R7 sllv 31");
    // R8 / R9
    apply(5'd14, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0, 5'd0, "R8 slt signed");
    apply(5'd15, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0, 5'd0, "R8 sltu unsigned");
    apply(5'd14, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0, "R8 slt extreme");
    apply(5'd18, 32'h0000_0001, 32'h0,         16'hFFFF, 5'd0, "R9 slti signed");
    apply(5'd19, 32'h0000_0001, 32'h0,         16'hFFFF, 5'd0, "R9 sltiu unsigned");
    // R10
    apply(5'd23, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hAC51, 5'd0, "R10 lui");
    // R11
    apply(5'd24, 32'h7FFF_FFFF, 32'h1,         16'hFFFF, 5'd5, "R11 code 24");
    apply(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, "R11 code 31");

    // Mixed stimulus across all codes, operands biased to the wrap points
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] c;
      c = 5'($urandom % 32);
      apply(c, pick(), pick(), 16'($urandom), 5'($urandom), "mixed");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule